// File: doc/BRIEF.md
# Shared-Pin Bidirectional Port

This block is a memory-mapped four-pin bidirectional port. Its pins sit on bit positions 7 to 4 of an eight-bit register word. Software sets each pin's direction and output value through two registers. It reads the pad levels through a third register, after a two-flop synchroniser. A simple read/write bus reaches all three registers: writes take effect on the clock edge, and reads are combinational.

The pins are shared with other blocks. A two-bit LCD multiplex setting chooses how many LCD commons are active. Each extra active common takes over one more pin of the lower group (pins 4, 5, 6, in that order). Pin 7 can be claimed by an LCD segment driver or, through a mapping configuration bit, by a capture/compare peripheral. The segment driver has priority. When another block owns a pin, that block supplies the pad's output enable and output value. The port's own direction and latch bits for the pin keep their contents and stay accessible over the bus. Per-pin ownership flags are brought out.

Top module: `gpio_share_port`

## Requirements
- R1: After reset, the direction register reads 0xF0 (all four pins inputs), the latch register reads 0x00, and every padOe bit is 0.
- R2: For a pin owned by general I/O, a direction bit of 0 drives padOe high and padOut to the pin's latch bit. A direction bit of 1 holds padOe low.
- R3: A read at address 1 returns the latch contents (bits 7:4), whatever the pad levels are.
- R4: A read at address 0 returns padIn (pad bit k on register bit k+4) two clock edges after the pads change, and not after one.
- R5: lcdMux value m gives the LCD commons ownership of pad bits k < m among bits 0..2 (pins 4..6). Each such pin has padOe=1, padOut=comDrive[k] and ownLcd[k]=1.
- R6: With segEnable=1, pad bit 3 (pin 7) is owned by the segment driver: ownLcd[3]=1, ownCcp[3]=0, padOe[3]=1 and padOut[3]=segDrive. This holds whatever ccpMapN is.
- R7: With segEnable=0 and ccpMapN=0, pin 7 is owned by the capture/compare peripheral: ownCcp[3]=1, padOe[3]=ccpOe and padOut[3]=ccpOut. With ccpMapN=1, pin 7 returns to general I/O.
- R8: On a pin owned by another block, writes to its direction and latch bits change nothing at the pad, but the written values still read back.
- R9: Register bits 3:0 read as 0 and ignore writes. Address 3 reads 0x00, and a write to it changes no register.
- R10: ccpIn carries the synchronised level of pin 7, two clock edges after padIn[3] changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address: 0 pins, 1 latch, 2 direction, 3 unused |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| lcdMux | input | 2 | Number of active LCD commons minus one |
| segEnable | input | 1 | LCD segment enable for pin 7 |
| ccpMapN | input | 1 | 0 routes the capture/compare peripheral to pin 7 |
| comDrive | input | 3 | LCD common output levels for pins 4..6 |
| segDrive | input | 1 | LCD segment output level for pin 7 |
| ccpOut | input | 1 | Capture/compare output level |
| ccpOe | input | 1 | Capture/compare output enable |
| ccpIn | output | 1 | Synchronised pin 7 level for the capture/compare peripheral |
| padIn | input | 4 | Pad input levels for pins 7..4 |
| padOe | output | 4 | Pad output enables for pins 7..4 |
| padOut | output | 4 | Pad output values for pins 7..4 |
| ownLcd | output | 4 | Pin owned by an LCD common or segment driver |
| ownCcp | output | 4 | Pin owned by the capture/compare peripheral |

## Verification
The bench uses the default parameters: eight-bit words, four pins starting at bit 4, and two synchroniser stages. With two stages, the pin-read latency is an exact two-edge window that the bench can probe on both sides. With four pins, every lcdMux value can be tested, and the three-way priority on pin 7 can be walked through all combinations of segEnable and ccpMapN.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrLat;
    logic   wrDir;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/gsp_ctrl.sv
module gsp_ctrl
  import gsp_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobes_t          stb
);
  localparam logic [ADDR_W-1:0] AddrPins = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AddrLat  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] AddrDir  = ADDR_W'(2);

  always_comb begin
    stb.wrLat = regWrEn && (regAddr == AddrLat);
    stb.wrDir = regWrEn && (regAddr == AddrDir);
    unique case (regAddr)
      AddrPins: stb.rdSel = SEL_PINS;
      AddrLat:  stb.rdSel = SEL_LAT;
      AddrDir:  stb.rdSel = SEL_DIR;
      default:  stb.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gsp_datapath.sv
module gsp_datapath
  import gsp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PIN_LO      = 4,
  parameter int PIN_CNT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [1:0]         lcdMux,
  input  logic               segEnable,
  input  logic               ccpMapN,
  input  logic [PIN_CNT-2:0] comDrive,
  input  logic               segDrive,
  input  logic               ccpOut,
  input  logic               ccpOe,
  output logic               ccpIn,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOe,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] ownLcd,
  output logic [PIN_CNT-1:0] ownCcp
);
  localparam int TOP = PIN_CNT - 1;

  logic [PIN_CNT-1:0] latQ, dirQ;
  logic [PIN_CNT-1:0] syncQ [SYNC_STAGES];
  logic [PIN_CNT-1:0] pinsSync;
  logic [PIN_CNT-1:0] periphOe, periphOut;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ <= '0;
      dirQ <= '1;
    end else begin
      if (stb.wrLat) latQ <= regWrData[PIN_LO +: PIN_CNT];
      if (stb.wrDir) dirQ <= regWrData[PIN_LO +: PIN_CNT];
    end
  end

  // input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= padIn;
  end
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinsSync = syncQ[SYNC_STAGES-1];
  assign ccpIn    = pinsSync[TOP];

  // ownership arbitration
  for (genvar k = 0; k < PIN_CNT; k++) begin : gPin
    if (k < TOP) begin : gCom
      assign ownLcd[k]    = int'(lcdMux) > k;
      assign ownCcp[k]    = 1'b0;
      assign periphOe[k]  = 1'b1;
      assign periphOut[k] = comDrive[k];
    end else begin : gSeg
      assign ownLcd[k]    = segEnable;
      assign ownCcp[k]    = !segEnable && !ccpMapN;
      assign periphOe[k]  = segEnable ? 1'b1 : ccpOe;
      assign periphOut[k] = segEnable ? segDrive : ccpOut;
    end
    always_comb begin
      if (ownLcd[k] || ownCcp[k]) begin
        padOe[k]  = periphOe[k];
        padOut[k] = periphOut[k];
      end else begin
        padOe[k]  = !dirQ[k];
        padOut[k] = latQ[k];
      end
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    unique case (stb.rdSel)
      SEL_PINS: regRdData[PIN_LO +: PIN_CNT] = pinsSync;
      SEL_LAT:  regRdData[PIN_LO +: PIN_CNT] = latQ;
      SEL_DIR:  regRdData[PIN_LO +: PIN_CNT] = dirQ;
      default:  regRdData = '0;
    endcase
  end

  // cycles since reset, saturating
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R1
  reset_dir_chk: assert property (@(posedge clk) !rstN |=> (dirQ == '1 && padOe == '0));

  // R3
  latch_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrLat |=> latQ == $past(regWrData[PIN_LO +: PIN_CNT]));

  // R5
  all_com_chk: assert property (@(posedge clk) disable iff (!rstN)
    lcdMux == 2'd3 |-> (padOe[TOP-1:0] == '1 && padOut[TOP-1:0] == comDrive));

  // R6
  seg_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    segEnable |-> (padOe[TOP] && padOut[TOP] == segDrive && !ownCcp[TOP]));

  // R7
  ccp_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!segEnable && !ccpMapN) |-> (padOe[TOP] == ccpOe && padOut[TOP] == ccpOut));

  // R4
  if (SYNC_STAGES == 2) begin : gSyncChk
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
      upCnt >= 2'd2 |-> pinsSync == $past(padIn, 2));
  end
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gsp_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int PIN_LO      = 4,
  parameter int PIN_CNT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [1:0]         lcdMux,
  input  logic               segEnable,
  input  logic               ccpMapN,
  input  logic [PIN_CNT-2:0] comDrive,
  input  logic               segDrive,
  input  logic               ccpOut,
  input  logic               ccpOe,
  output logic               ccpIn,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOe,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] ownLcd,
  output logic [PIN_CNT-1:0] ownCcp
);
  strobes_t stb;

  gsp_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .stb(stb)
  );

  gsp_datapath #(
    .DATA_W(DATA_W), .PIN_LO(PIN_LO), .PIN_CNT(PIN_CNT), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .regWrData(regWrData), .regRdData(regRdData),
    .lcdMux(lcdMux), .segEnable(segEnable), .ccpMapN(ccpMapN),
    .comDrive(comDrive), .segDrive(segDrive), .ccpOut(ccpOut), .ccpOe(ccpOe),
    .ccpIn(ccpIn), .padIn(padIn), .padOe(padOe), .padOut(padOut),
    .ownLcd(ownLcd), .ownCcp(ownCcp)
  );
endmodule

// File: tb/sim_gpio_share_port.sv
module sim_gpio_share_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] lcdMux = '0;
  logic       segEnable = 0;
  logic       ccpMapN = 1;
  logic [2:0] comDrive = '0;
  logic       segDrive = 0;
  logic       ccpOut = 0;
  logic       ccpOe = 0;
  logic       ccpIn;
  logic [3:0] padIn = '0;
  logic [3:0] padOe, padOut, ownLcd, ownCcp;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_share_port u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .lcdMux(lcdMux),
    .segEnable(segEnable), .ccpMapN(ccpMapN), .comDrive(comDrive),
    .segDrive(segDrive), .ccpOut(ccpOut), .ccpOe(ccpOe), .ccpIn(ccpIn),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .ownLcd(ownLcd), .ownCcp(ownCcp)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic tReset();
    logic [7:0] d;
    regRead(2'd2, d); check("R1 dir", d, 8'hF0);
    regRead(2'd1, d); check("R1 lat", d, 8'h00);
    check("R1 padOe", padOe, 4'h0);
  endtask

  task automatic tGpioDrive();
    regWrite(2'd1, 8'h50);
    regWrite(2'd2, 8'h00);
    #1;
    check("R2 oe", padOe, 4'hF);
    check("R2 out", padOut, 4'h5);
    regWrite(2'd2, 8'hA0);
    #1;
    check("R2 partial oe", padOe, 4'h5);
  endtask

  task automatic tLatchRead();
    logic [7:0] d;
    regWrite(2'd2, 8'hF0);
    regWrite(2'd1, 8'hA0);
    padIn = 4'h5;
    repeat (3) @(negedge clk);
    regRead(2'd1, d); check("R3 latch not pins", d, 8'hA0);
  endtask

  task automatic tSyncRead();
    logic [7:0] d;
    @(negedge clk); padIn = 4'h0;
    repeat (3) @(negedge clk);
    padIn = 4'h9;
    @(negedge clk);
    regRead(2'd0, d); check("R4 one edge", d, 8'h00);
    @(negedge clk);
    regRead(2'd0, d); check("R4 two edges", d, 8'h90);
  endtask

  task automatic tLcdMux();
    regWrite(2'd2, 8'hF0);
    comDrive = 3'b101;
    for (int m = 0; m < 4; m++) begin
      logic [2:0] mask;
      lcdMux = 2'(m);
      mask = 3'((1 << m) - 1);
      #1;
      check($sformatf("R5 own m=%0d", m), ownLcd[2:0], mask);
      check($sformatf("R5 oe m=%0d", m), padOe[2:0], mask);
      check($sformatf("R5 out m=%0d", m), padOut[2:0] & mask, 3'b101 & mask);
    end
    lcdMux = 0;
  endtask

  task automatic tPin7Seg();
    regWrite(2'd2, 8'hF0);
    segEnable = 1; ccpMapN = 0; ccpOe = 0; segDrive = 1;
    #1;
    check("R6 ownLcd", ownLcd[3], 1);
    check("R6 ownCcp", ownCcp[3], 0);
    check("R6 oe", padOe[3], 1);
    check("R6 out", padOut[3], 1);
    segDrive = 0; #1;
    check("R6 out low", padOut[3], 0);
  endtask

  task automatic tPin7Ccp();
    segEnable = 0; ccpMapN = 0; ccpOe = 0; ccpOut = 1;
    #1;
    check("R7 own", ownCcp[3], 1);
    check("R7 oe off", padOe[3], 0);
    ccpOe = 1; #1;
    check("R7 oe on", padOe[3], 1);
    check("R7 out", padOut[3], 1);
    ccpMapN = 1; #1;
    check("R7 released own", {ownLcd[3], ownCcp[3]}, 2'b00);
    check("R7 released oe", padOe[3], 0);
    ccpOe = 0;
  endtask

  task automatic tOwnedIgnores();
    logic [7:0] d;
    lcdMux = 2'd3; segEnable = 1; comDrive = 3'b111; segDrive = 1;
    regWrite(2'd2, 8'hF0);
    regWrite(2'd1, 8'h00);
    regWrite(2'd2, 8'h00);
    #1;
    check("R8 oe", padOe, 4'hF);
    check("R8 out", padOut, 4'hF);
    regRead(2'd2, d); check("R8 dir readback", d, 8'h00);
    regWrite(2'd1, 8'hC0);
    #1;
    check("R8 out after latch wr", padOut, 4'hF);
    regRead(2'd1, d); check("R8 lat readback", d, 8'hC0);
    lcdMux = 0; segEnable = 0;
  endtask

  task automatic tUnused();
    logic [7:0] d;
    regWrite(2'd1, 8'h3F);
    regRead(2'd1, d); check("R9 low bits lat", d, 8'h30);
    regWrite(2'd2, 8'h0F);
    regRead(2'd2, d); check("R9 low bits dir", d, 8'h00);
    regWrite(2'd3, 8'hFF);
    regRead(2'd3, d); check("R9 addr3 read", d, 8'h00);
    regRead(2'd1, d); check("R9 addr3 no lat", d, 8'h30);
    regRead(2'd2, d); check("R9 addr3 no dir", d, 8'h00);
  endtask

  task automatic tCcpIn();
    @(negedge clk); padIn = 4'h0;
    repeat (3) @(negedge clk);
    padIn = 4'h8;
    @(negedge clk);
    check("R10 one edge", ccpIn, 0);
    @(negedge clk);
    check("R10 two edges", ccpIn, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tGpioDrive();
    tLatchRead();
    tSyncRead();
    tLcdMux();
    tPin7Seg();
    tPin7Ccp();
    tOwnedIgnores();
    tUnused();
    tCcpIn();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule